// File: doc/BRIEF.md
# Path REI-P Generator and Inserter

This block closes the path error-monitoring loop for one STS-3c path. On the receive side it takes the SPE byte stream with a byte-valid qualifier, a first-byte-of-SPE strobe and a B3-position strobe. It accumulates even bit-interleaved parity (BIP-8) over every valid byte of each SPE. It then compares that parity with the B3 byte found in the following SPE. The comparison yields a remote error indication (REI-P) value. Depending on a control bit, that value is either the count of mismatched B3 bits or a single errored-SPE flag.

On the transmit side, the block passes the outgoing byte stream through one register stage. When the G1 position is strobed, it replaces the upper nibble of G1 with the selected REI-P value. The lower nibble of G1 is taken from a separate input driven by the RDI-P logic. A small write-only register port selects where the REI-P value comes from: the automatic receive result, a software value, or an external 4-bit input. The same port also selects the error-reporting style.

Top module: `path_rei_gen`

## Requirements
- R1: After rst_ni is released, tx_data_o is 0x00. All three registers read as zero, which means automatic source, bit-count style and a software value of 0. The automatic REI-P value is 0.
- R2: Parity is the XOR of every byte accepted while rx_spe_vld_i=1, starting at the byte that carries rx_spe_start_i and running up to the byte before the next start. The B3 byte is included. Bytes presented while rx_spe_vld_i=0 are ignored.
- R3: With register address 1, bit 0 equal to 0 (count style), the automatic REI-P value becomes the number of bits, 0 to 8, in which the received B3 byte differs from the parity of the previous SPE.
- R4: With register address 1, bit 0 equal to 1 (flag style), the automatic REI-P value becomes 1 if any B3 bit differs and 0 otherwise.
- R5: The automatic value is updated only by the first B3 strobe that follows an SPE start, and only if a complete SPE precedes that start. Otherwise it holds. Before the first check after reset it is 0.
- R6: A byte presented with tx_g1_pos_i=1 leaves one cycle later as tx_data_o[7:4] = the REI-P value (G1 bits 1 to 4, sent first) and tx_data_o[3:0] = tx_g1_low_i.
- R7: A byte presented with tx_g1_pos_i=0 leaves unchanged on tx_data_o one cycle later.
- R8: Register address 0, bits 6:5, select the REI-P source: 00 and 11 select automatic, 01 selects register address 2 bits 3:0, and 10 selects rei_ext_i. A write takes effect from the next cycle.
- R9: When a G1 strobe and a B3 check fall in the same cycle, G1 carries the automatic value from before that check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 transmit control, 1 receive control, 2 software REI-P |
| reg_wdata_i | input | 8 | Register write data |
| rx_data_i | input | 8 | Received SPE byte |
| rx_spe_vld_i | input | 1 | Received byte belongs to the SPE |
| rx_spe_start_i | input | 1 | First byte of an SPE |
| rx_b3_pos_i | input | 1 | Received byte is B3 |
| tx_data_i | input | 8 | Outgoing byte before insertion |
| tx_g1_pos_i | input | 1 | Outgoing byte is G1 |
| tx_g1_low_i | input | 4 | G1 bits 5 to 8 (RDI-P and spare) |
| rei_ext_i | input | 4 | External REI-P value |
| tx_data_o | output | 8 | Outgoing byte after insertion, one cycle delayed |

## Verification
A B3 check on the receive side and a G1 insertion on the transmit side can fall in the same clock. The bench provokes this with a frame that strobes tx_g1_pos_i in the same cycle as rx_b3_pos_i. It then judges the G1 byte against the value computed from the previous SPE, and confirms that the G1 of the next frame carries the new result. A behavioural model, stepped every cycle with the inputs of that cycle, predicts every tx_data_o byte. Targeted checks cover the count, flag, software, external and 11-alias paths, a duplicate B3 strobe, the first incomplete SPE, and a gap byte with valid low.

// File: rtl/path_rei_pkg.sv
package path_rei_pkg;
  typedef enum logic [1:0] {
    SRC_AUTO     = 2'b00,
    SRC_SW       = 2'b01,
    SRC_EXT      = 2'b10,
    SRC_AUTO_ALT = 2'b11
  } rei_src_e;

  localparam logic [1:0] ADDR_TX_CTRL = 2'd0;
  localparam logic [1:0] ADDR_RX_CTRL = 2'd1;
  localparam logic [1:0] ADDR_SW_REI  = 2'd2;

  localparam int unsigned SRC_LSB  = 5;
  localparam int unsigned FLAG_BIT = 0;
endpackage

// File: rtl/rei_regs.sv
module rei_regs
  import path_rei_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REI_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output rei_src_e          src_o,
  output logic              flag_mode_o,
  output logic [REI_W-1:0]  sw_rei_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o       <= SRC_AUTO;
      flag_mode_o <= 1'b0;
      sw_rei_o    <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_TX_CTRL: src_o       <= rei_src_e'(wdata_i[SRC_LSB +: 2]);
        ADDR_RX_CTRL: flag_mode_o <= wdata_i[FLAG_BIT];
        ADDR_SW_REI:  sw_rei_o    <= wdata_i[REI_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/b3_checker.sv
module b3_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REI_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              vld_i,
  input  logic              start_i,
  input  logic              b3_pos_i,
  input  logic              flag_mode_i,
  output logic [REI_W-1:0]  rei_o,
  output logic              check_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] acc_q, prev_bip_q, diff;
  logic              have_spe_q, armed_q;
  logic [CNT_W-1:0]  err_cnt;

  assign diff    = prev_bip_q ^ data_i;
  assign check_o = vld_i && b3_pos_i && !start_i && armed_q;

  always_comb begin
    err_cnt = '0;
    for (int i = 0; i < DATA_W; i++) err_cnt = err_cnt + CNT_W'(diff[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      prev_bip_q <= '0;
      have_spe_q <= 1'b0;
      armed_q    <= 1'b0;
      rei_o      <= '0;
    end else if (vld_i) begin
      if (start_i) begin
        prev_bip_q <= acc_q;
        acc_q      <= data_i;
        armed_q    <= have_spe_q;
        have_spe_q <= 1'b1;
      end else begin
        acc_q <= acc_q ^ data_i;
        if (check_o) begin
          armed_q <= 1'b0;
          rei_o   <= flag_mode_i ? REI_W'(|diff) : REI_W'(err_cnt);
        end
      end
    end
  end
endmodule

// File: rtl/g1_inserter.sv
module g1_inserter
  import path_rei_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REI_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DATA_W-1:0]       data_i,
  input  logic                    g1_pos_i,
  input  logic [DATA_W-REI_W-1:0] g1_low_i,
  input  rei_src_e                src_i,
  input  logic [REI_W-1:0]        auto_rei_i,
  input  logic [REI_W-1:0]        sw_rei_i,
  input  logic [REI_W-1:0]        ext_rei_i,
  output logic [DATA_W-1:0]       data_o
);
  logic [REI_W-1:0] rei_sel;

  always_comb begin
    case (src_i)
      SRC_SW:  rei_sel = sw_rei_i;
      SRC_EXT: rei_sel = ext_rei_i;
      default: rei_sel = auto_rei_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= g1_pos_i ? {rei_sel, g1_low_i} : data_i;
  end
endmodule

// File: rtl/path_rei_gen.sv
module path_rei_gen
  import path_rei_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REI_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [1:0]              reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  input  logic [DATA_W-1:0]       rx_data_i,
  input  logic                    rx_spe_vld_i,
  input  logic                    rx_spe_start_i,
  input  logic                    rx_b3_pos_i,
  input  logic [DATA_W-1:0]       tx_data_i,
  input  logic                    tx_g1_pos_i,
  input  logic [DATA_W-REI_W-1:0] tx_g1_low_i,
  input  logic [REI_W-1:0]        rei_ext_i,
  output logic [DATA_W-1:0]       tx_data_o
);
  rei_src_e         rei_src;
  logic             err_flag_mode;
  logic [REI_W-1:0] sw_rei, rei_auto;
  logic             chk_vld;

  rei_regs #(.DATA_W(DATA_W), .REI_W(REI_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .src_o(rei_src), .flag_mode_o(err_flag_mode), .sw_rei_o(sw_rei)
  );

  b3_checker #(.DATA_W(DATA_W), .REI_W(REI_W)) u_b3 (
    .clk_i, .rst_ni,
    .data_i(rx_data_i), .vld_i(rx_spe_vld_i), .start_i(rx_spe_start_i),
    .b3_pos_i(rx_b3_pos_i), .flag_mode_i(err_flag_mode),
    .rei_o(rei_auto), .check_o(chk_vld)
  );

  g1_inserter #(.DATA_W(DATA_W), .REI_W(REI_W)) u_ins (
    .clk_i, .rst_ni,
    .data_i(tx_data_i), .g1_pos_i(tx_g1_pos_i), .g1_low_i(tx_g1_low_i),
    .src_i(rei_src), .auto_rei_i(rei_auto), .sw_rei_i(sw_rei),
    .ext_rei_i(rei_ext_i), .data_o(tx_data_o)
  );
endmodule

// File: rtl/path_rei_gen_chk.sv
module path_rei_gen_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REI_W  = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [DATA_W-1:0]       tx_data_i,
  input logic                    tx_g1_pos_i,
  input logic [DATA_W-REI_W-1:0] tx_g1_low_i,
  input logic [DATA_W-1:0]       tx_data_o,
  input logic [REI_W-1:0]        rei_auto,
  input logic                    chk_vld,
  input logic                    err_flag_mode
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b0;
    else if (chk_vld) seen_q <= 1'b1;
  end

  AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(rei_auto) <= DATA_W); // R3
  AST_FLAG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_vld && err_flag_mode |=> rei_auto <= 1); // R4
  AST_HOLD_NO_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_vld |=> $stable(rei_auto)); // R5
  AST_ZERO_BEFORE_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> rei_auto == '0); // R5
  AST_G1_LOW_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_g1_pos_i |=> tx_data_o[DATA_W-REI_W-1:0] == $past(tx_g1_low_i)); // R6
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_g1_pos_i |=> tx_data_o == $past(tx_data_i)); // R7
endmodule

bind path_rei_gen path_rei_gen_chk #(.DATA_W(DATA_W), .REI_W(REI_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .tx_data_i(tx_data_i), .tx_g1_pos_i(tx_g1_pos_i), .tx_g1_low_i(tx_g1_low_i),
  .tx_data_o(tx_data_o), .rei_auto(rei_auto), .chk_vld(chk_vld),
  .err_flag_mode(err_flag_mode)
);

// File: tb/path_rei_gen_tb.sv
module path_rei_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rxd = '0;
  logic       vld = 1'b0, st = 1'b0, b3 = 1'b0;
  logic [7:0] txd = '0;
  logic       g1 = 1'b0;
  logic [3:0] low = '0, ext = '0;
  logic [7:0] txo;

  int checks = 0, errors = 0;
  // model state
  logic [7:0] m_acc = 0, m_prev = 0, m_out = 0;
  bit         m_have = 0, m_armed = 0, m_flag = 0;
  int         m_rei = 0, m_src = 0, m_sw = 0;
  logic [7:0] bip_prev = 0, bip_cur = 0;
  logic [7:0] g1_obs;
  int         seed = 3;

  path_rei_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .rx_data_i(rxd), .rx_spe_vld_i(vld),
    .rx_spe_start_i(st), .rx_b3_pos_i(b3), .tx_data_i(txd),
    .tx_g1_pos_i(g1), .tx_g1_low_i(low), .rei_ext_i(ext), .tx_data_o(txo)
  );

  always #5 clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: model evaluated with pre-edge state, then compared after edge
  task automatic tick();
    int nib, n;
    nib = (m_src == 1) ? m_sw : (m_src == 2) ? int'(ext) : m_rei;
    m_out = g1 ? {4'(nib), low} : txd;
    if (vld) begin
      if (st) begin
        m_prev = m_acc; m_acc = rxd; m_armed = m_have; m_have = 1;
      end else begin
        m_acc = m_acc ^ rxd;
        if (b3 && m_armed) begin
          n = $countones(m_prev ^ rxd);
          m_rei = m_flag ? int'(n != 0) : n;
          m_armed = 0;
        end
      end
    end
    if (we) case (addr)
      2'd0: m_src = int'(wd[6:5]);
      2'd1: m_flag = wd[0];
      2'd2: m_sw = int'(wd[3:0]);
      default: ;
    endcase
    @(posedge clk); #1;
    check(txo, m_out, g1 ? "R6 g1 byte" : "R7 pass byte");
  endtask

  task automatic idle();
    {we, vld, st, b3, g1} = '0;
    txd = 8'(seed * 29 + 1); seed++;
    tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    idle(); we = 1; addr = a; wd = d;
    {vld, st, b3, g1} = '0; tick(); we = 0;
  endtask

  // 10-slot frame: 0 start, 1 G1, 2 gap (vld low), 3 B3, 6 optional repeated B3
  task automatic frame(input logic [7:0] mask, input bit g1_at_b3, input bit dup,
                       input logic [3:0] exp_nib, input string tag);
    bip_cur = 0;
    for (int k = 0; k < 10; k++) begin
      {we, st, b3, g1} = '0; vld = 1;
      rxd = 8'(seed * 37 + k * 11); txd = 8'(seed + k * 5);
      low = 4'(k + seed); ext = 4'hC;
      if (k == 0) st = 1;
      if (k == 2) begin vld = 0; rxd = 8'h5A; end
      if (k == 3) begin b3 = 1; rxd = bip_prev ^ mask; end
      if (k == 6 && dup) begin b3 = 1; rxd = bip_prev ^ 8'hFF; end
      if ((k == 1 && !g1_at_b3) || (k == 3 && g1_at_b3)) g1 = 1;
      if (vld) bip_cur = bip_cur ^ rxd;
      tick();
      if (g1) begin
        g1_obs = txo;
        check({4'(g1_obs[7:4]), 4'h0}, {exp_nib, 4'h0}, tag);
        check({4'h0, 4'(g1_obs[3:0])}, {4'h0, low}, "R6 low nibble");
      end
    end
    seed++;
    bip_prev = bip_cur;
    idle();
  endtask

  initial begin
    #200;
    @(negedge clk); rst_n = 1; #1;
    check(txo, 8'h00, "R1 reset output");
    frame(8'h00, 0, 0, 4'd0, "R1 automatic REI zero after reset");
    frame(8'h07, 0, 0, 4'd0, "R5 no check before first full SPE");
    frame(8'hFF, 0, 0, 4'd3, "R3 three bits / R2 gap ignored");
    frame(8'h00, 0, 1, 4'd8, "R3 eight bits");
    frame(8'h00, 0, 0, 4'd0, "R5 repeated B3 ignored");
    wr(2'd1, 8'h01);
    frame(8'h81, 0, 0, 4'd0, "R3 zero mismatches");
    frame(8'h00, 1, 0, 4'd1, "R9 coincident G1 carries prior value / R4");
    frame(8'h10, 0, 0, 4'd0, "R4 clean SPE");
    wr(2'd2, 8'hF9); wr(2'd0, 8'h20);
    frame(8'h00, 0, 0, 4'd9, "R8 software source");
    wr(2'd0, 8'h40);
    frame(8'h3C, 0, 0, 4'hC, "R8 external source");
    wr(2'd0, 8'h60);
    frame(8'h00, 0, 0, 4'd1, "R8 code 11 is automatic / R4 flag");
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    frame(8'h0F, 0, 0, 4'd0, "R8 automatic restored");
    for (int i = 0; i < 20; i++) idle();
    frame(8'h00, 0, 0, 4'd4, "R3 four bits held across idle / R5");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule